// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one start request into a string of column addresses, one per clock, for a memory burst of 2, 4 or 8 beats. The caller gives a starting column, a length code and an ordering mode, then pulses a start strobe. On each following cycle the block presents the next column of the burst. It also raises a valid flag, and it raises a last-beat flag together with the final column.

The burst stays inside an aligned block of the column space. The block size equals the burst length, and the column bits above the block offset stay fixed for the whole burst. Only the offset bits move. They move in one of two ways. In wrapping order the offset counts upward and rolls over at the block end. In XOR order each offset is the starting offset XORed with the beat number.

Control is a two-state machine. `ST_IDLE` waits for a start strobe. The transition `IDLE->RUN` is taken when a strobe is accepted, and it latches the column, length and mode. In `ST_RUN` the transition `RUN->RUN` advances the beat counter while beats remain. The transition `RUN->IDLE` is taken on the edge that ends the final beat.

Top module: `burst_col_seq`

## Requirements
- R1: The length codes on `len_i` are 2'b01 for 2 beats, 2'b10 for 4 beats and 2'b11 for 8 beats. `valid_o` is high for exactly that many consecutive cycles, starting in the cycle after the clock edge that samples `start_i` high while idle.
- R2: Length code 2'b00 produces a 2-beat burst.
- R3: The first beat's `col_o` equals the `col_i` sampled with the accepted start.
- R4: The block offset is bit 0 for 2 beats, bits 1:0 for 4 beats and bits 2:0 for 8 beats. Every column bit above the offset keeps the value of the sampled `col_i` for every beat.
- R5: With `mode_i`=0, the offset of beat k is (start offset + k) modulo the burst length.
- R6: With `mode_i`=1, the offset of beat k is (start offset XOR k).
- R7: `last_o` is high only in the cycle of the final beat.
- R8: `busy_o` is high during every beat. A start strobe that arrives while busy adds no beats and changes no addresses.
- R9: Changes to `col_i`, `len_i` and `mode_i` during a burst do not alter that burst.
- R10: After reset, and whenever no burst runs, `valid_o`, `last_o` and `busy_o` are low and `col_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| col_i | input | COL_W | Starting column |
| len_i | input | 2 | Burst length code |
| mode_i | input | 1 | 0 wrapping order, 1 XOR order |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of the burst |
| busy_o | output | 1 | A burst is running |

## Verification
Every length code is combined with both ordering modes and all eight starting offsets, using a column whose upper bits are not zero.

Offset zero must give the same ascending order in both modes. Nonzero offsets separate wrapping addition from XOR, and they show whether the rollover stays inside the aligned block. The 2'b00 code separates the fallback length from the others.

Part of the sweep is repeated with the inputs changed and the strobe pulsed during the burst. Those runs show that the latched settings hold and that a busy strobe is ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int unsigned OFS_W = 3;
    localparam int unsigned MAX_BEATS = 1 << OFS_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        LEN_FALLBACK = 2'b00,
        LEN_TWO      = 2'b01,
        LEN_FOUR     = 2'b10,
        LEN_EIGHT    = 2'b11
    } len_code_e;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
    import bcs_pkg::*;
(
    input  logic [1:0]       code_i,
    output logic [OFS_W-1:0] mask_o
);
    always_comb begin
        unique case (len_code_e'(code_i))
            LEN_FOUR:  mask_o = 3'b011;
            LEN_EIGHT: mask_o = 3'b111;
            default:   mask_o = 3'b001;
        endcase
    end
endmodule

// File: rtl/bcs_beat_order.sv
module bcs_beat_order
    import bcs_pkg::*;
(
    input  logic [OFS_W-1:0] base_ofs_i,
    input  logic [OFS_W-1:0] idx_i,
    input  logic [OFS_W-1:0] mask_i,
    input  order_e           mode_i,
    output logic [OFS_W-1:0] low_o
);
    logic [OFS_W-1:0] start_ofs;
    logic [OFS_W-1:0] wrap_ofs;
    logic [OFS_W-1:0] xor_ofs;

    always_comb begin
        start_ofs = base_ofs_i & mask_i;
        wrap_ofs  = (start_ofs + idx_i) & mask_i;
        xor_ofs   = (start_ofs ^ idx_i) & mask_i;
        unique case (mode_i)
            ORD_XOR:  low_o = (base_ofs_i & ~mask_i) | xor_ofs;
            default:  low_o = (base_ofs_i & ~mask_i) | wrap_ofs;
        endcase
    end
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OFS_W-1:0] final_idx_i,
    output logic             accept_o,
    output logic             running_o,
    output logic             final_o,
    output logic [OFS_W-1:0] idx_o
);
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [OFS_W-1:0] idx_q;
    logic             at_final;

    assign at_final = (idx_q == final_idx_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_RUN;
            ST_RUN:  if (at_final) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                idx_q <= '0;
            else if (!at_final)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        accept_o  = 1'b0;
        running_o = 1'b0;
        final_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start_i;
            ST_RUN: begin
                running_o = 1'b1;
                final_o   = at_final;
            end
            default: ;
        endcase
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       len_i,
    input  logic             mode_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o
);
    localparam int unsigned UP_W = COL_W - OFS_W;

    logic [COL_W-1:0] col_q;
    logic [OFS_W-1:0] mask_q;
    order_e           mode_q;
    logic [OFS_W-1:0] mask_new;
    logic             accept;
    logic             running;
    logic             final_beat;
    logic [OFS_W-1:0] idx;
    logic [OFS_W-1:0] low;

    bcs_len_dec u_len (
        .code_i (len_i),
        .mask_o (mask_new)
    );

    bcs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .final_idx_i (mask_q),
        .accept_o    (accept),
        .running_o   (running),
        .final_o     (final_beat),
        .idx_o       (idx)
    );

    bcs_beat_order u_order (
        .base_ofs_i (col_q[OFS_W-1:0]),
        .idx_i      (idx),
        .mask_i     (mask_q),
        .mode_i     (mode_q),
        .low_o      (low)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            mask_q <= 3'b001;
            mode_q <= ORD_WRAP;
        end else if (accept) begin
            col_q  <= col_i;
            mask_q <= mask_new;
            mode_q <= order_e'(mode_i);
        end
    end

    always_comb begin
        col_o   = '0;
        valid_o = running;
        busy_o  = running;
        last_o  = final_beat;
        if (running)
            col_o = {col_q[COL_W-1 -: UP_W], low};
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int unsigned COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             busy_o
);
    a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (valid_o && col_o == $past(col_i)));

    a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o);

    a_r5_beats_differ: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (col_o != $past(col_o)));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0 && !last_o));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (col_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .busy_o  (busy_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
    localparam int unsigned COL_W = 10;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0]       len_i = '0;
    logic             mode_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             busy_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .col_i   (col_i),
        .len_i   (len_i),
        .mode_i  (mode_i),
        .col_o   (col_o),
        .valid_o (valid_o),
        .last_o  (last_o),
        .busy_o  (busy_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic run_burst(input int code, input int mode, input int col, input bit perturb);
        int beats;
        int mask;
        int ofs;
        int low;
        int exp_col;
        string tag;
        string ltag;
        beats = (code == 3) ? 8 : (code == 2) ? 4 : 2;
        mask  = beats - 1;
        ofs   = col & mask;
        tag   = mode ? "R6" : "R5";
        ltag  = (code == 0) ? "R2" : "R1";
        @(negedge clk);
        start_i = 1'b1;
        col_i   = col[COL_W-1:0];
        len_i   = code[1:0];
        mode_i  = mode[0];
        for (int k = 0; k < beats; k++) begin
            @(negedge clk);
            low     = mode ? (ofs ^ k) : ((ofs + k) & mask);
            exp_col = (col & ~mask) | low;
            check(perturb ? "R9" : tag, int'(col_o), exp_col);
            check(ltag, int'(valid_o), 1);
            check("R8", int'(busy_o), 1);
            check("R7", int'(last_o), (k == beats - 1) ? 1 : 0);
            if (k == 0)
                check("R3", int'(col_o), col);
            if (k != 0 || perturb)
                check("R4", int'(col_o) & ~mask & ((1 << COL_W) - 1), col & ~mask);
            if (perturb) begin
                start_i = 1'b1;
                col_i   = ~col_i;
                len_i   = ~len_i;
                mode_i  = ~mode_i;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        @(negedge clk);
        check(ltag, int'(valid_o), 0);
        check("R10", int'(busy_o), 0);
        check("R10", int'(col_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", int'(valid_o), 0);
        check("R10", int'(busy_o), 0);
        check("R10", int'(last_o), 0);
        check("R10", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int code = 0; code < 4; code++)
            for (int mode = 0; mode < 2; mode++)
                for (int o = 0; o < 8; o++)
                    run_burst(code, mode, 10'h2A8 | o, 1'b0);
        for (int code = 0; code < 4; code++)
            for (int mode = 0; mode < 2; mode++)
                for (int o = 0; o < 8; o += 3)
                    run_burst(code, mode, 10'h150 | o, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule